// File: doc/BRIEF.md
# I2C Byte DMA Engine

This block is a private data mover that belongs to a single I2C controller. Software programs a transmit buffer address and byte count, a receive buffer address and byte count, and a direction. It then sets the start bit. From there the engine moves bytes between a byte-wide memory port and the controller's byte streams without further help from software.

There are three kinds of transfer. In a send transfer, bytes are fetched from memory and offered to the controller. In a receive transfer, bytes taken from the controller are written to memory. A combined write-then-read transfer also selects the send direction but has both counts non-zero: one start runs the whole send phase first and then the whole receive phase. When the last byte has been moved, the start bit drops, a completion flag is raised, and an interrupt line follows that flag if it is enabled.

The register bank is 32 bits wide with single-cycle writes and combinational reads. The memory side keeps at most one byte request in flight.

Top module: `i2c_byte_dma`

## Requirements
- R1: After reset every register reads 0, `irq` is 0, and `mem_req`, `tx_valid` and `rx_ready` are 0.
- R2: The register offsets are as follows. 0x00 is the flag (bit0), 0x04 is the interrupt enable (bit0), 0x08 is the enable (bit0), 0x18 is the direction (bit0: 0 = send, 1 = receive), 0x1C is the send address, 0x20 is the receive address, 0x24 is the send count and 0x28 is the receive count. Addresses and counts read back the value last written, and this holds both during and after a transfer.
- R3: Writing 0x08 with bit0 = 1 while the enable bit is 0 starts a transfer and sets the enable bit. A write to 0x08 while the enable bit is 1 is ignored, and a write with bit0 = 0 starts nothing.
- R4: With direction 0, the engine reads the send-count bytes from consecutive ascending addresses, starting at the send address. It offers each byte on `tx_byte`/`tx_valid` in that order and holds each byte until `tx_ready` accepts it.
- R5: The memory port has at most one request outstanding. `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` stay stable until `mem_ack`. `mem_we` = 0 marks a read, and `mem_rdata` is taken in the cycle where `mem_ack` is high.
- R6: With direction 1, the engine stores the receive-count bytes taken on `rx_valid`/`rx_ready` at consecutive ascending addresses, starting at the receive address. The send count has no effect in this mode.
- R7: With direction 0 and both counts non-zero, every send byte is accepted before any receive byte is accepted. Then the receive-count bytes are stored as in R6.
- R8: When the last byte has been moved (the last `tx_ready` acceptance, or the last memory write acknowledgement), the enable bit returns to 0 and flag bit0 becomes 1.
- R9: `irq` equals flag bit0 AND interrupt-enable bit0.
- R10: If every count in the selected mode is zero, the transfer completes without any memory or stream activity and sets the flag.
- R11: Software writes to 0x00 set flag bit0 to the written bit0. Writing 0 clears it, and this also clears `irq`.
- R12: While the enable bit is 0, no memory request is made, no byte is offered, and no byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Completion interrupt |
| mem_req | output | 1 | Memory byte request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_ack | input | 1 | Memory request accepted / read data valid |
| mem_rdata | input | 8 | Memory read byte |
| tx_byte | output | 8 | Byte offered to the I2C controller |
| tx_valid | output | 1 | Send byte valid |
| tx_ready | input | 1 | Controller accepts the send byte |
| rx_byte | input | 8 | Byte from the I2C controller |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Engine accepts the receive byte |

## Verification
The engine is exercised with send-only, receive-only and combined transfers. Memory acknowledges and stream handshakes are stalled at pseudo-random times, so that ordering and hold behaviour are tested under back-pressure. The receive-only run is given a non-zero send count, which shows whether that count leaks into the receive mode. The combined run records how many send bytes had gone out when the first receive byte was taken; this separates a correct phase order from an interleaved one. Runs with zero counts, with the interrupt disabled and then enabled, and with a second start during a transfer test the completion, flag and ignore rules.

// File: rtl/i2c_byte_dma_pkg.sv
// Shared definitions for the I2C byte DMA engine.
package i2c_byte_dma_pkg;
    localparam int REG_ADDR_W = 6;
    localparam logic [REG_ADDR_W-1:0] OFS_FLAG   = 6'h00;
    localparam logic [REG_ADDR_W-1:0] OFS_IEN    = 6'h04;
    localparam logic [REG_ADDR_W-1:0] OFS_ENABLE = 6'h08;
    localparam logic [REG_ADDR_W-1:0] OFS_DIR    = 6'h18;
    localparam logic [REG_ADDR_W-1:0] OFS_TXADR  = 6'h1C;
    localparam logic [REG_ADDR_W-1:0] OFS_RXADR  = 6'h20;
    localparam logic [REG_ADDR_W-1:0] OFS_TXCNT  = 6'h24;
    localparam logic [REG_ADDR_W-1:0] OFS_RXCNT  = 6'h28;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_OFFER, ST_TAKE, ST_STORE, ST_FINISH
    } seq_state_t;
endpackage

// File: rtl/dma_reg_bank.sv
// Register bank: holds the programmed setup, the enable, flag and interrupt
// enable bits, and produces the start pulse.
// Assumes the sequencer raises done for exactly one cycle per transfer.
module dma_reg_bank
    import i2c_byte_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic                  done,
    output logic                  start,
    output logic                  busy,
    output logic                  dir_rx,
    output logic                  irq,
    output logic [ADDR_W-1:0]     tx_addr,
    output logic [ADDR_W-1:0]     rx_addr,
    output logic [LEN_W-1:0]      tx_len,
    output logic [LEN_W-1:0]      rx_len
);
    logic flag_q, ien_q, en_q;

    // A start is a write of 1 to the enable bit while no transfer runs.
    assign start = reg_we && (reg_addr == OFS_ENABLE) && reg_wdata[0] && !en_q;
    assign busy  = en_q;
    assign irq   = flag_q & ien_q;

    // Control bits: enable, flag and interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            ien_q  <= 1'b0;
            en_q   <= 1'b0;
        end else begin
            if (start)
                en_q <= 1'b1;
            else if (done)
                en_q <= 1'b0;
            if (done)
                flag_q <= 1'b1;
            else if (reg_we && reg_addr == OFS_FLAG)
                flag_q <= reg_wdata[0];
            if (reg_we && reg_addr == OFS_IEN)
                ien_q <= reg_wdata[0];
        end
    end

    // Setup registers: direction, addresses and byte counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_rx  <= 1'b0;
            tx_addr <= '0;
            rx_addr <= '0;
            tx_len  <= '0;
            rx_len  <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                OFS_DIR:   dir_rx  <= reg_wdata[0];
                OFS_TXADR: tx_addr <= reg_wdata[ADDR_W-1:0];
                OFS_RXADR: rx_addr <= reg_wdata[ADDR_W-1:0];
                OFS_TXCNT: tx_len  <= reg_wdata[LEN_W-1:0];
                OFS_RXCNT: rx_len  <= reg_wdata[LEN_W-1:0];
                default: ;
            endcase
        end
    end

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_FLAG:   reg_rdata[0] = flag_q;
            OFS_IEN:    reg_rdata[0] = ien_q;
            OFS_ENABLE: reg_rdata[0] = en_q;
            OFS_DIR:    reg_rdata[0] = dir_rx;
            OFS_TXADR:  reg_rdata[ADDR_W-1:0] = tx_addr;
            OFS_RXADR:  reg_rdata[ADDR_W-1:0] = rx_addr;
            OFS_TXCNT:  reg_rdata[LEN_W-1:0]  = tx_len;
            OFS_RXCNT:  reg_rdata[LEN_W-1:0]  = rx_len;
            default: ;
        endcase
    end

    AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> flag_q && !en_q); // R8
endmodule

// File: rtl/dma_sequencer.sv
// Transfer sequencer: walks the send phase and then the receive phase.
// It keeps its own working address and count copies, so the programmed
// registers are never modified. Assumes start is only raised while idle.
module dma_sequencer
    import i2c_byte_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              busy,
    input  logic              dir_rx,
    input  logic [ADDR_W-1:0] tx_addr,
    input  logic [ADDR_W-1:0] rx_addr,
    input  logic [LEN_W-1:0]  tx_len,
    input  logic [LEN_W-1:0]  rx_len,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ack,
    input  logic [7:0]        mem_rdata,
    output logic [7:0]        tx_byte,
    output logic              tx_valid,
    input  logic              tx_ready,
    input  logic [7:0]        rx_byte,
    input  logic              rx_valid,
    output logic              rx_ready
);
    seq_state_t        state;
    logic [ADDR_W-1:0] cur_addr, rx_base;
    logic [LEN_W-1:0]  left, rx_left;
    logic [7:0]        data_q;

    assign mem_req   = (state == ST_FETCH) || (state == ST_STORE);
    assign mem_we    = (state == ST_STORE);
    assign mem_addr  = cur_addr;
    assign mem_wdata = data_q;
    assign tx_byte   = data_q;
    assign tx_valid  = (state == ST_OFFER);
    assign rx_ready  = (state == ST_TAKE);
    assign done      = (state == ST_FINISH);

    // Main state machine with working address, count and data registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cur_addr <= '0;
            rx_base  <= '0;
            left     <= '0;
            rx_left  <= '0;
            data_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    rx_base <= rx_addr;
                    rx_left <= rx_len;
                    if (!dir_rx && tx_len != '0) begin
                        cur_addr <= tx_addr;
                        left     <= tx_len;
                        state    <= ST_FETCH;
                    end else if (rx_len != '0) begin
                        cur_addr <= rx_addr;
                        left     <= rx_len;
                        state    <= ST_TAKE;
                    end else
                        state <= ST_FINISH;
                end
                ST_FETCH: if (mem_ack) begin
                    data_q <= mem_rdata;
                    state  <= ST_OFFER;
                end
                ST_OFFER: if (tx_ready) begin
                    if (left == LEN_W'(1)) begin
                        if (rx_left != '0) begin
                            cur_addr <= rx_base;
                            left     <= rx_left;
                            state    <= ST_TAKE;
                        end else
                            state <= ST_FINISH;
                    end else begin
                        cur_addr <= cur_addr + 1'b1;
                        left     <= left - 1'b1;
                        state    <= ST_FETCH;
                    end
                end
                ST_TAKE: if (rx_valid) begin
                    data_q <= rx_byte;
                    state  <= ST_STORE;
                end
                ST_STORE: if (mem_ack) begin
                    if (left == LEN_W'(1))
                        state <= ST_FINISH;
                    else begin
                        cur_addr <= cur_addr + 1'b1;
                        left     <= left - 1'b1;
                        state    <= ST_TAKE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R5
    AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte)); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req && !tx_valid && !rx_ready); // R12
    AST_ONE_ACTIVITY: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({mem_req, tx_valid, rx_ready}) <= 1); // R5
endmodule

// File: rtl/i2c_byte_dma.sv
// Top of the I2C byte DMA engine: register bank plus transfer sequencer.
// Assumes a single-port byte memory with a request/acknowledge handshake.
module i2c_byte_dma
    import i2c_byte_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [5:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ack,
    input  logic [7:0]        mem_rdata,
    output logic [7:0]        tx_byte,
    output logic              tx_valid,
    input  logic              tx_ready,
    input  logic [7:0]        rx_byte,
    input  logic              rx_valid,
    output logic              rx_ready
);
    logic              start, busy, dir_rx, done;
    logic [ADDR_W-1:0] tx_addr, rx_addr;
    logic [LEN_W-1:0]  tx_len, rx_len;

    dma_reg_bank #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(32)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .done(done),
        .start(start), .busy(busy), .dir_rx(dir_rx), .irq(irq),
        .tx_addr(tx_addr), .rx_addr(rx_addr), .tx_len(tx_len), .rx_len(rx_len)
    );

    dma_sequencer #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .dir_rx(dir_rx),
        .tx_addr(tx_addr), .rx_addr(rx_addr), .tx_len(tx_len), .rx_len(rx_len),
        .done(done), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_ready(rx_ready)
    );

    AST_IRQ_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(done) || $past(reg_we)); // R9
endmodule

// File: tb/sim_i2c_byte_dma.sv
module sim_i2c_byte_dma;
    logic        clk = 0, rst_n = 0;
    logic        reg_we = 0;
    logic [5:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic        irq, mem_req, mem_we, mem_ack = 0;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata = 0, tx_byte, rx_byte = 0;
    logic        tx_valid, tx_ready = 0, rx_valid = 0, rx_ready;

    int checks = 0, errors = 0;
    logic [7:0] mem [256];
    logic [7:0] txlog [64];
    int tx_cnt = 0, rx_cnt = 0, rx_idx = 0, tx_at_first_rx = -1, mem_acts = 0;
    logic rx_on = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    i2c_byte_dma u0 (.*);

    // Models of memory and I2C controller, updated away from the active edge.
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_ack  = mem_req && lfsr[0];
        tx_ready = lfsr[1] | lfsr[2];
        rx_valid = rx_on && lfsr[3];
        rx_byte  = 8'hA0 + 8'(rx_idx);
        if (mem_ack) begin
            mem_acts++;
            if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
            else mem_rdata = mem[mem_addr[7:0]];
        end
        if (tx_valid && tx_ready) begin
            txlog[tx_cnt[5:0]] = tx_byte;
            tx_cnt++;
        end
        if (rx_valid && rx_ready) begin
            if (rx_cnt == 0) tx_at_first_rx = tx_cnt;
            rx_cnt++;
            rx_idx++;
        end
    end

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 5000; i++) begin
            rd(6'h08, v);
            if (v[0] == 1'b0) return;
        end
        chk("R8 enable never cleared", 1, 0);
    endtask

    task automatic reset_counters();
        tx_cnt = 0; rx_cnt = 0; rx_idx = 0; tx_at_first_rx = -1; mem_acts = 0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int i = 0; i < 11; i++) begin
            rd(6'(i * 4), v);
            chk("R1 register reset", v, 0);
        end
        chk("R1 irq", irq, 0);
        chk("R1 idle outputs", {mem_req, tx_valid, rx_ready}, 0);
    endtask

    task automatic t_readback();
        logic [31:0] v;
        wr(6'h1C, 32'h1234_5610); wr(6'h20, 32'hCAFE_0080);
        wr(6'h24, 32'h0000_0005); wr(6'h28, 32'h0000_0003);
        rd(6'h1C, v); chk("R2 send address", v, 32'h1234_5610);
        rd(6'h20, v); chk("R2 receive address", v, 32'hCAFE_0080);
        rd(6'h24, v); chk("R2 send count", v, 5);
        rd(6'h28, v); chk("R2 receive count", v, 3);
        wr(6'h08, 0);
        rd(6'h08, v); chk("R3 bit0=0 starts nothing", v, 0);
    endtask

    task automatic t_send();
        logic [31:0] v;
        reset_counters();
        for (int i = 0; i < 8; i++) mem[8'h10 + i] = 8'h30 + 8'(i * 7);
        wr(6'h18, 0); wr(6'h1C, 32'h10); wr(6'h24, 8); wr(6'h28, 0);
        wr(6'h00, 0); wr(6'h04, 0);
        wr(6'h08, 1);
        rd(6'h08, v); chk("R3 enable set by start", v, 1);
        wr(6'h08, 1); // second start during a transfer must be ignored
        wait_idle();
        chk("R3 R4 send byte count", tx_cnt, 8);
        for (int i = 0; i < 8; i++) chk("R4 send order", txlog[i], 8'h30 + 8'(i * 7));
        rd(6'h00, v); chk("R8 flag after send", v, 1);
        chk("R9 irq masked", irq, 0);
        wr(6'h04, 1);
        #1 chk("R9 irq enabled", irq, 1);
        wr(6'h00, 0);
        #1 chk("R11 flag clear drops irq", irq, 0);
        rd(6'h00, v); chk("R11 flag cleared", v, 0);
        rd(6'h24, v); chk("R2 count unchanged after run", v, 8);
    endtask

    task automatic t_receive();
        reset_counters();
        rx_on = 1;
        wr(6'h18, 1); wr(6'h20, 32'h80); wr(6'h28, 6); wr(6'h24, 4);
        wr(6'h08, 1);
        wait_idle();
        rx_on = 0;
        chk("R6 bytes sent in receive mode", tx_cnt, 0);
        chk("R6 receive count", rx_cnt, 6);
        for (int i = 0; i < 6; i++) chk("R6 stored byte", mem[8'h80 + i], 8'hA0 + 8'(i));
        chk("R9 irq on receive done", irq, 1);
        wr(6'h00, 0);
    endtask

    task automatic t_combined();
        reset_counters();
        for (int i = 0; i < 3; i++) mem[8'h40 + i] = 8'h55 + 8'(i);
        rx_on = 1;
        wr(6'h18, 0); wr(6'h1C, 32'h40); wr(6'h24, 3);
        wr(6'h20, 32'hC0); wr(6'h28, 4);
        wr(6'h08, 1);
        wait_idle();
        rx_on = 0;
        chk("R7 send count", tx_cnt, 3);
        chk("R7 phase order", tx_at_first_rx, 3);
        chk("R7 receive count", rx_cnt, 4);
        for (int i = 0; i < 3; i++) chk("R7 send byte", txlog[i], 8'h55 + 8'(i));
        for (int i = 0; i < 4; i++) chk("R7 stored byte", mem[8'hC0 + i], 8'hA0 + 8'(i));
        wr(6'h00, 0);
    endtask

    task automatic t_zero();
        logic [31:0] v;
        reset_counters();
        wr(6'h18, 0); wr(6'h24, 0); wr(6'h28, 0);
        wr(6'h08, 1);
        repeat (3) @(negedge clk);
        rd(6'h08, v); chk("R10 zero count enable cleared", v, 0);
        rd(6'h00, v); chk("R10 zero count flag", v, 1);
        chk("R10 no memory activity", mem_acts, 0);
        wr(6'h00, 0);
        wr(6'h18, 1); wr(6'h24, 5);
        wr(6'h08, 1);
        repeat (3) @(negedge clk);
        rd(6'h00, v); chk("R10 receive zero count flag", v, 1);
        chk("R10 R6 no send bytes", tx_cnt, 0);
        chk("R12 quiet when idle", {mem_req, tx_valid, rx_ready}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_readback();
        t_send();
        t_receive();
        t_combined();
        t_zero();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule